// File: doc/BRIEF.md
# Stack Bytecode Interpreter Core

This block runs a small subset of a stack-machine bytecode directly in hardware. A byte-wide code memory is filled through a load port. A one-cycle start pulse then begins execution at a chosen byte address. The engine fetches one opcode byte at a time. An opcode that carries an inline byte argument also fetches the byte that follows it. The engine works on an operand stack of 32-bit words and on four 32-bit local-variable slots.

The supported operations are:
- push an inline byte, sign-extended;
- push the constant zero;
- copy local 1 or local 2 onto the stack;
- pop the top into local 1, 2 or 3;
- add the top two entries;
- return.

The slot number is part of the opcode and is not an operand. Return ends the run with a done flag. Three faults end the run with an error flag instead: a stack underflow, a stack overflow, or an opcode outside the subset. A registered read port lets the environment inspect any local slot after a run.

Top module: `bc_engine`

## Requirements
- R1: After reset, busy, done and error are 0 and every local slot reads 0.
- R2: A start pulse while idle clears done, error and the stack, and begins fetching at start_addr. Busy is 1 from the next cycle until the run ends. A later start runs again even after an error.
- R3: Opcode 0x10 pushes the following code byte sign-extended to 32 bits (0xF6 becomes 0xFFFFFFF6). Execution then continues at the byte after that argument.
- R4: Opcodes 0x3C, 0x3D and 0x3E pop the stack top into local slots 1, 2 and 3 respectively.
- R5: Opcodes 0x1B and 0x1C push the contents of local slots 1 and 2 respectively.
- R6: Opcode 0x03 pushes the value 0.
- R7: Opcode 0x60 pops two entries and pushes their sum modulo 2^32, with no overflow indication (0xFFFFFFFF + 1 gives 0).
- R8: Opcode 0xB1 ends the run. Done becomes 1 and busy becomes 0, and done holds until the next start. Done and error are never 1 together.
- R9: A store with an empty stack, or an add with fewer than two entries, sets error, ends the run and writes no local slot.
- R10: The stack holds STACK_DEPTH entries. Filling it exactly is legal. A push onto a full stack sets error and ends the run.
- R11: Any opcode other than 0x03, 0x10, 0x1B, 0x1C, 0x3C, 0x3D, 0x3E, 0x60 and 0xB1 sets error and ends the run.
- R12: The program 10 0F 3C 10 09 3D 03 3E 1B 1C 60 3E B1 ends with done set and 15, 9 and 24 in local slots 1, 2 and 3.
- R13: local_q shows the slot chosen by local_sel one cycle after local_sel is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Write enable for the code memory |
| load_addr | input | CODE_AW | Code memory write address |
| load_data | input | 8 | Code byte to write |
| start | input | 1 | Begins a run when idle |
| start_addr | input | CODE_AW | Address of the first opcode |
| local_sel | input | LOCAL_SW | Local slot to show on local_q |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended on return |
| error | output | 1 | Last run ended on a fault |
| local_q | output | WORD_W | Registered contents of the selected slot |

## Verification
The bench pushes a negative inline byte and checks the result. A core that zero-extends the byte, or that fails to skip past the argument, leaves a wrong value in a slot or runs the argument byte as an opcode.

An add of 0xFFFFFFFF and 1 must give 0. The bench also fills the stack to exactly its depth and then to one entry beyond it. An off-by-one full test either faults a legal program or accepts an overflow.

A store on an empty stack must leave the previously written slot untouched. An unlisted opcode (the load for slot 3) must fault. A rerun after a fault must clear the error flag.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam logic [7:0] OPC_ZERO  = 8'h03;
  localparam logic [7:0] OPC_PUSHB = 8'h10;
  localparam logic [7:0] OPC_LD1   = 8'h1B;
  localparam logic [7:0] OPC_LD2   = 8'h1C;
  localparam logic [7:0] OPC_ST1   = 8'h3C;
  localparam logic [7:0] OPC_ST2   = 8'h3D;
  localparam logic [7:0] OPC_ST3   = 8'h3E;
  localparam logic [7:0] OPC_ADD   = 8'h60;
  localparam logic [7:0] OPC_RET   = 8'hB1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_ARG
  } eng_state_t;

  typedef enum logic [1:0] {
    SK_NONE,
    SK_PUSH,
    SK_POP,
    SK_FOLD
  } stk_op_t;
endpackage

// File: rtl/bc_code_mem.sv
module bc_code_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int BYTES = 1 << AW;

  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bc_operand_stack.sv
module bc_operand_stack
  import bc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  stk_op_t       op,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [W-1:0]  second,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  ent [DEPTH];
  logic [PW-1:0] p_top, p_sec, p_new;

  assign p_top = PW'(count - CW'(1));
  assign p_sec = PW'(count - CW'(2));
  assign p_new = PW'(count);

  assign top    = (count != '0)      ? ent[p_top] : '0;
  assign second = (count >= CW'(2))  ? ent[p_sec] : '0;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else begin
      case (op)
        SK_PUSH: begin
          ent[p_new] <= din;
          count      <= count + CW'(1);
        end
        SK_POP:  count <= count - CW'(1);
        SK_FOLD: begin
          ent[p_sec] <= din;
          count      <= count - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_push_room_R10: assert property (@(posedge clk) disable iff (rst)
    (op == SK_PUSH) |-> (count < CW'(DEPTH)));
  assert_pop_room_R9: assert property (@(posedge clk) disable iff (rst)
    (op == SK_POP) |-> (count != '0));
  assert_fold_room_R9: assert property (@(posedge clk) disable iff (rst)
    (op == SK_FOLD) |-> (count >= CW'(2)));
endmodule

// File: rtl/bc_locals.sv
module bc_locals #(
  parameter int NSLOT = 4,
  parameter int W     = 32,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel,
  output logic [W-1:0]  rdata,
  input  logic [SW-1:0] peek_sel,
  output logic [W-1:0]  peek_q
);
  logic [W-1:0] slot [NSLOT];

  assign rdata = slot[rsel];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                      slot[g] <= '0;
      else if (we && wsel == SW'(g)) slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) peek_q <= '0;
    else     peek_q <= slot[peek_sel];
  end

  assert_peek_follows_R13: assert property (@(posedge clk) disable iff (rst)
    $stable(peek_sel) && !we && !$past(we) |=> peek_q == $past(peek_q));
endmodule

// File: rtl/bc_engine.sv
module bc_engine
  import bc_pkg::*;
#(
  parameter int CODE_AW     = 8,
  parameter int STACK_DEPTH = 16,
  parameter int WORD_W      = 32,
  parameter int NUM_LOCALS  = 4,
  parameter int LOCAL_SW    = $clog2(NUM_LOCALS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_we,
  input  logic [CODE_AW-1:0]  load_addr,
  input  logic [7:0]          load_data,
  input  logic                start,
  input  logic [CODE_AW-1:0]  start_addr,
  input  logic [LOCAL_SW-1:0] local_sel,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [WORD_W-1:0]   local_q
);
  localparam int CW = $clog2(STACK_DEPTH + 1);

  eng_state_t          state;
  logic [CODE_AW-1:0]  pc;
  logic [7:0]          code_q;

  stk_op_t             sk_op;
  logic [WORD_W-1:0]   sk_din, sk_top, sk_sec;
  logic [CW-1:0]       sk_count;
  logic                sk_clear, sk_full, sk_empty, sk_short;

  logic                lv_we;
  logic [LOCAL_SW-1:0] lv_wsel, lv_rsel;
  logic [WORD_W-1:0]   lv_rdata;

  logic                fault, finish, take_arg;

  bc_code_mem #(.AW(CODE_AW)) u_code (
    .clk  (clk),
    .we   (load_we),
    .waddr(load_addr),
    .wdata(load_data),
    .raddr(pc),
    .rdata(code_q)
  );

  bc_operand_stack #(.DEPTH(STACK_DEPTH), .W(WORD_W), .CW(CW)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .clear (sk_clear),
    .op    (sk_op),
    .din   (sk_din),
    .top   (sk_top),
    .second(sk_sec),
    .count (sk_count)
  );

  bc_locals #(.NSLOT(NUM_LOCALS), .W(WORD_W), .SW(LOCAL_SW)) u_locals (
    .clk     (clk),
    .rst     (rst),
    .we      (lv_we),
    .wsel    (lv_wsel),
    .wdata   (sk_top),
    .rsel    (lv_rsel),
    .rdata   (lv_rdata),
    .peek_sel(local_sel),
    .peek_q  (local_q)
  );

  assign sk_full  = (sk_count == CW'(STACK_DEPTH));
  assign sk_empty = (sk_count == '0);
  assign sk_short = (sk_count < CW'(2));
  assign sk_clear = (state == ST_IDLE) && start;

  // Decode of the opcode byte; slot numbers come from the opcode itself.
  always_comb begin
    sk_op    = SK_NONE;
    sk_din   = '0;
    lv_we    = 1'b0;
    lv_wsel  = '0;
    lv_rsel  = '0;
    fault    = 1'b0;
    finish   = 1'b0;
    take_arg = 1'b0;
    if (state == ST_EXEC) begin
      case (code_q)
        OPC_PUSHB: take_arg = 1'b1;
        OPC_ZERO: begin
          if (sk_full) fault = 1'b1;
          else         sk_op = SK_PUSH;
        end
        OPC_LD1, OPC_LD2: begin
          lv_rsel = (code_q == OPC_LD1) ? LOCAL_SW'(1) : LOCAL_SW'(2);
          sk_din  = lv_rdata;
          if (sk_full) fault = 1'b1;
          else         sk_op = SK_PUSH;
        end
        OPC_ST1, OPC_ST2, OPC_ST3: begin
          lv_wsel = (code_q == OPC_ST1) ? LOCAL_SW'(1) :
                    (code_q == OPC_ST2) ? LOCAL_SW'(2) : LOCAL_SW'(3);
          if (sk_empty) fault = 1'b1;
          else begin
            sk_op = SK_POP;
            lv_we = 1'b1;
          end
        end
        OPC_ADD: begin
          sk_din = sk_top + sk_sec;
          if (sk_short) fault = 1'b1;
          else          sk_op = SK_FOLD;
        end
        OPC_RET: finish = 1'b1;
        default: fault = 1'b1;
      endcase
    end else if (state == ST_ARG) begin
      sk_din = {{(WORD_W-8){code_q[7]}}, code_q};
      if (sk_full) fault = 1'b1;
      else         sk_op = SK_PUSH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pc    <= start_addr;
          state <= ST_FETCH;
          busy  <= 1'b1;
          done  <= 1'b0;
          error <= 1'b0;
        end
        ST_FETCH: begin
          pc    <= pc + CODE_AW'(1);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (fault) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (finish) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (take_arg) begin
            pc    <= pc + CODE_AW'(1);
            state <= ST_ARG;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_ARG: begin
          if (fault) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> busy && !done && !error);
  assert_fault_halts_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> !busy && state == ST_IDLE);
  assert_add_sum_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && code_q == OPC_ADD && !fault) |=>
      sk_top == $past(sk_top + sk_sec));
  assert_sext_push_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARG && !fault) |=>
      sk_top == {{(WORD_W-8){$past(code_q[7])}}, $past(code_q)});
endmodule

// File: tb/test_bc_engine.sv
module test_bc_engine;
  localparam int AW  = 8;
  localparam int W   = 32;
  localparam int LSW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load_we = 1'b0;
  logic [AW-1:0]  load_addr = '0;
  logic [7:0]     load_data = '0;
  logic           start = 1'b0;
  logic [AW-1:0]  start_addr = '0;
  logic [LSW-1:0] local_sel = '0;
  logic           busy, done, error;
  logic [W-1:0]   local_q;

  always #5 clk = ~clk;

  bc_engine #(.CODE_AW(AW), .STACK_DEPTH(16), .WORD_W(W), .NUM_LOCALS(4)) i_bc_engine (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .start(start), .start_addr(start_addr),
    .local_sel(local_sel), .busy(busy), .done(done), .error(error),
    .local_q(local_q)
  );

  typedef struct {
    bit             is_local;
    logic [LSW-1:0] sel;
    logic [W-1:0]   exp;
    string          req;
  } sb_item_t;

  sb_item_t   sb_q[$];
  int         n_push = 0, n_pop = 0, n_cmp = 0, n_bad = 0;
  logic [7:0] prog[$];

  task automatic exp_local(input int sel, input logic [W-1:0] v, input string r);
    sb_item_t it;
    it.is_local = 1'b1; it.sel = LSW'(sel); it.exp = v; it.req = r;
    sb_q.push_back(it); n_push++;
  endtask

  // status word is {busy, done, error}
  task automatic exp_status(input logic [2:0] s, input string r);
    sb_item_t it;
    it.is_local = 1'b0; it.sel = '0; it.exp = {29'b0, s}; it.req = r;
    sb_q.push_back(it); n_push++;
  endtask

  task automatic drain();
    wait (n_pop == n_push);
  endtask

  // monitor: pops expected items and compares them with what the design shows
  initial begin
    sb_item_t it;
    logic [W-1:0] got;
    forever begin
      wait (n_push != n_pop);
      it = sb_q.pop_front();
      if (it.is_local) begin
        @(negedge clk) local_sel = it.sel;
        @(negedge clk) got = local_q;
      end else begin
        @(negedge clk) got = {29'b0, busy, done, error};
      end
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: %s got %h expected %h", it.req,
                 it.is_local ? "local" : "status", got, it.exp);
      end
      n_pop++;
    end
  end

  task automatic load_prog(input int base);
    foreach (prog[i]) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = AW'(base + i); load_data = prog[i];
    end
    @(negedge clk) load_we = 1'b0;
  endtask

  task automatic run_prog(input int base, input string r);
    int g;
    @(negedge clk); start = 1'b1; start_addr = AW'(base);
    @(negedge clk); start = 1'b0;
    g = 0;
    while (busy && g < 1000) begin
      @(negedge clk); g++;
    end
    if (g >= 1000) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: run did not end got busy=%b expected busy=0", r, busy);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no end expected end of test");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    exp_status(3'b000, "R1");
    for (int s = 0; s < 4; s++) exp_local(s, 32'd0, "R1");
    drain();

    // R12 reference program at 0x00
    prog = '{8'h10, 8'h0F, 8'h3C, 8'h10, 8'h09, 8'h3D, 8'h03, 8'h3E,
             8'h1B, 8'h1C, 8'h60, 8'h3E, 8'hB1};
    load_prog(8'h00);
    run_prog(8'h00, "R12");
    exp_status(3'b010, "R8");
    exp_local(1, 32'd15, "R12");
    exp_local(2, 32'd9,  "R12");
    exp_local(3, 32'd24, "R12");
    exp_local(0, 32'd0,  "R13");
    exp_status(3'b010, "R8 done held");
    drain();

    // R3 negative byte, R5 loads, R6 zero, R2 nonzero start address
    prog = '{8'h10, 8'hF6, 8'h3C, 8'h1B, 8'h1B, 8'h60, 8'h3D, 8'h03, 8'h3C, 8'hB1};
    load_prog(8'h40);
    run_prog(8'h40, "R2");
    exp_status(3'b010, "R2");
    exp_local(2, 32'hFFFF_FFEC, "R3");
    exp_local(1, 32'd0, "R6");
    exp_local(3, 32'd24, "R4");
    drain();

    // R7 wrap: 0xFFFFFFFF + 1 into slot 3
    prog = '{8'h10, 8'hFF, 8'h10, 8'h01, 8'h60, 8'h3E, 8'hB1};
    load_prog(8'h60);
    run_prog(8'h60, "R7");
    exp_status(3'b010, "R7");
    exp_local(3, 32'd0, "R7");
    drain();

    // R9 add with a single entry
    prog = '{8'h10, 8'h05, 8'h60, 8'hB1};
    load_prog(8'h70);
    run_prog(8'h70, "R9");
    exp_status(3'b001, "R9 add underflow");
    drain();

    // R9 store on empty stack leaves slot 1 at 7
    prog = '{8'h10, 8'h07, 8'h3C, 8'h3C, 8'hB1};
    load_prog(8'h78);
    run_prog(8'h78, "R9");
    exp_status(3'b001, "R9 store underflow");
    exp_local(1, 32'd7, "R9");
    drain();

    // R11 unsupported opcode (load of slot 3)
    prog = '{8'h03, 8'h1D, 8'hB1};
    load_prog(8'h88);
    run_prog(8'h88, "R11");
    exp_status(3'b001, "R11");
    drain();

    // R10 exactly full is legal
    prog = {};
    repeat (16) prog.push_back(8'h03);
    prog.push_back(8'hB1);
    load_prog(8'hA0);
    run_prog(8'hA0, "R10");
    exp_status(3'b010, "R10 full legal");
    drain();

    // R10 one push beyond full
    prog = {};
    repeat (17) prog.push_back(8'h03);
    prog.push_back(8'hB1);
    load_prog(8'hC0);
    run_prog(8'hC0, "R10");
    exp_status(3'b001, "R10 overflow");
    drain();

    // R2 rerun after an error clears it
    run_prog(8'h00, "R2");
    exp_status(3'b010, "R2 rerun");
    exp_local(3, 32'd24, "R12 rerun");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule